// File: doc/BRIEF.md
# Lockable Indexed Configuration Register Bank

This block holds a small set of chip configuration registers behind a two-location access port. A write to the index location picks a register. A later access to the data location then reads or writes that register. The stored bits are decoded into control outputs:

- power-down requests for clock stop or oscillator stop;
- interrupt line choice and interrupt style for the parallel port;
- the enable and float control of a shared printer/floppy pin multiplexer, with blocking of its inputs;
- the selection between data-rate outputs and media-sense inputs;
- the two peripheral test-mode enables;
- a logical exchange of the drive-select and motor signals of floppy drives 0 and 1.

A lock bit set by software freezes every configuration register until the next hardware reset. A strap input is sampled during reset into the rate-select bit.

The block is used by a host interface that drives `bus_wr_i`, `bus_port_i` and `bus_wdata_i` and reads `bus_rdata_o`. The decoded outputs feed the peripheral functions and the pin logic. Those functions are not part of this block.

Top module: `cfg_bank_top`

## Requirements
- R1: With `bus_port_i`=0 a write loads the index and a read returns it. With `bus_port_i`=1 a write stores `bus_wdata_i` into the indexed register and a read returns its contents. Index 0 is the select register, 1 is the power register and 2 is the pin register.
- R2: An index of 3 or above reads as zero on the data location. Data writes to it change no implemented register.
- R3: Reset is synchronous and active low. It sets the select and power registers to 0. It sets the pin register to 0 except bit 0, which takes the value of `strap_rate_i` during reset.
- R4: Bit 6 of the power register is a lock. The write that sets it stores all its bits. From then on every data write is ignored, and only reset clears the lock. Index writes stay allowed while locked.
- R5: Bit 2 of the power register and bit 1 of the pin register always read 0, whatever was written to them.
- R6: Define the request as `pwrdn_pin_i` OR power bit 0. `clk_stop_o` is the request AND NOT power bit 1. `osc_stop_o` is the request AND power bit 1.
- R7: Select bits [1:0] code the parallel port base: 00=3BCh, 01=378h, 10=278h, 11=none. `lpt_irq7_o` equals power bit 3 only for code 01 and is 0 for every other code.
- R8: `lpt_level_o` equals power bit 7 (0 = pulse interrupts, 1 = level interrupts).
- R9: `uart_test_o[1:0]` equals power bits [5:4].
- R10: `pmux_en_o` equals pin bit 2 and `pmux_drive_o` equals NOT pin bit 3. While pin bit 3 is 1, `pmux_in_o` is held at 5'b10011. Otherwise it follows `pmux_in_i`.
- R11: When pin bit 4 is 1 and select bit 4 (four-drive mode) is 0, `pin_ds_o` and `pin_mtr_o` are `fdc_ds_i` and `fdc_mtr_i` with bits 0 and 1 swapped. In every other case they pass through unchanged.
- R12: `rate_out_o` equals pin bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strap_rate_i | input | 1 | Strap sampled into the rate-select bit during reset |
| pwrdn_pin_i | input | 1 | External power-down request |
| bus_wr_i | input | 1 | Write strobe for one cycle |
| bus_port_i | input | 1 | 0 = index location, 1 = data location |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data of the addressed location |
| fdc_ds_i | input | 2 | Drive selects from the floppy controller |
| fdc_mtr_i | input | 2 | Motor enables from the floppy controller |
| pin_ds_o | output | 2 | Drive selects toward the pins |
| pin_mtr_o | output | 2 | Motor enables toward the pins |
| pmux_in_i | input | 5 | Raw inputs of the shared pin multiplexer |
| pmux_in_o | output | 5 | Multiplexer inputs after blocking |
| pmux_en_o | output | 1 | Multiplexer set to floppy use |
| pmux_drive_o | output | 1 | Multiplexer outputs driven (0 = float) |
| clk_stop_o | output | 1 | Stop internal clocks |
| osc_stop_o | output | 1 | Stop the oscillator |
| uart_test_o | output | 2 | Test-mode enables of the two serial ports |
| lpt_irq7_o | output | 1 | Parallel port on IRQ7 (0 = IRQ5) |
| lpt_level_o | output | 1 | Level interrupts for the parallel port |
| rate_out_o | output | 1 | Data-rate outputs selected over media sense |

## Verification
Every register sits one clock edge from the bus. The bench drives a write on a falling edge, so the rising edge that follows captures it. It samples the register readback and every decoded output on the next falling edge, one cycle after the write. `bus_rdata_o`, the power outputs, the drive swap and the multiplexer input blocking are combinational from the stored bits and the live inputs. The bench therefore reads them 1 ns after it changes the port select or an input, within the same cycle. The bench checks lock and reset behaviour only after the clock edge that would have applied the blocked write or the reset.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
   localparam int unsigned IDX_SEL = 0;
   localparam int unsigned IDX_PWR = 1;
   localparam int unsigned IDX_PIN = 2;
   localparam int unsigned REG_CNT = 3;

   // select register fields
   localparam int unsigned SEL_FOURDRV = 4;
   // power register fields
   localparam int unsigned PWR_SWDN    = 0;
   localparam int unsigned PWR_OSC     = 1;
   localparam int unsigned PWR_RSVD    = 2;
   localparam int unsigned PWR_IRQ7    = 3;
   localparam int unsigned PWR_TST0    = 4;
   localparam int unsigned PWR_TST1    = 5;
   localparam int unsigned PWR_LOCK    = 6;
   localparam int unsigned PWR_LEVEL   = 7;
   // pin register fields
   localparam int unsigned PIN_RATE    = 0;
   localparam int unsigned PIN_RSVD    = 1;
   localparam int unsigned PIN_MUXEN   = 2;
   localparam int unsigned PIN_FLOAT   = 3;
   localparam int unsigned PIN_XCHG    = 4;

   typedef enum logic [1:0] {
      BASE_3BC  = 2'b00,
      BASE_378  = 2'b01,
      BASE_278  = 2'b10,
      BASE_NONE = 2'b11
   } lpt_base_e;
endpackage

// File: rtl/cfg_reg_store.sv
module cfg_reg_store
   import cfg_bank_pkg::*;
#(
   parameter int unsigned DW   = 8,
   parameter int unsigned IW   = 8,
   parameter int unsigned NREG = REG_CNT
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     strap_i,
   input  logic                     wr_i,
   input  logic                     port_i,
   input  logic [DW-1:0]            wdata_i,
   output logic [DW-1:0]            rdata_o,
   output logic [NREG-1:0][DW-1:0]  regs_o,
   output logic [IW-1:0]            idx_o,
   output logic                     lock_o
);
   localparam logic [DW-1:0] ONE = DW'(1);

   if (DW < 8) begin : g_dw_chk
      $error("cfg_reg_store: DW must be at least 8");
   end
   if (IW > DW) begin : g_iw_chk
      $error("cfg_reg_store: IW must not exceed DW");
   end
   if (NREG != REG_CNT) begin : g_nreg_chk
      $error("cfg_reg_store: NREG must match the register map");
   end

   function automatic logic [DW-1:0] keep_mask(int unsigned k);
      logic [DW-1:0] m;
      m = '1;
      if (k == IDX_PWR) m[PWR_RSVD] = 1'b0;
      if (k == IDX_PIN) m[PIN_RSVD] = 1'b0;
      return m;
   endfunction

   logic [IW-1:0] idx_q;
   logic          data_wr;

   assign data_wr = wr_i & port_i & ~lock_o;

   always_ff @(posedge clk) begin
      if (!rst_n)              idx_q <= '0;
      else if (wr_i && !port_i) idx_q <= wdata_i[IW-1:0];
   end

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [DW-1:0] q;
      logic [DW-1:0] rst_val;
      assign rst_val = (g == IDX_PIN) ? (strap_i ? ONE << PIN_RATE : '0) : '0;
      always_ff @(posedge clk) begin
         if (!rst_n)                            q <= rst_val;
         else if (data_wr && idx_q == IW'(g))   q <= wdata_i & keep_mask(g);
      end
      assign regs_o[g] = q;
   end

   assign lock_o = regs_o[IDX_PWR][PWR_LOCK];
   assign idx_o  = idx_q;

   always_comb begin
      rdata_o = '0;
      if (!port_i) begin
         rdata_o[IW-1:0] = idx_q;
      end else begin
         for (int k = 0; k < NREG; k++) begin
            if (idx_q == IW'(k)) rdata_o = regs_o[k];
         end
      end
   end
endmodule

// File: rtl/cfg_lpt_route.sv
module cfg_lpt_route
   import cfg_bank_pkg::*;
#(
   parameter logic [1:0] ROUTE_CODE = BASE_378
) (
   input  logic [1:0] base_i,
   input  logic       irq_sel_i,
   input  logic       mode_i,
   output logic       irq7_o,
   output logic       level_o
);
   always_comb begin
      irq7_o = 1'b0;
      if (base_i == ROUTE_CODE) irq7_o = irq_sel_i;
   end
   assign level_o = mode_i;
endmodule

// File: rtl/cfg_drive_swap.sv
module cfg_drive_swap #(
   parameter int unsigned NDRV    = 2,
   parameter bit          SWAP_EN = 1'b1
) (
   input  logic            swap_i,
   input  logic [NDRV-1:0] ds_i,
   input  logic [NDRV-1:0] mtr_i,
   output logic [NDRV-1:0] ds_o,
   output logic [NDRV-1:0] mtr_o
);
   if (NDRV < 2) begin : g_ndrv_chk
      $error("cfg_drive_swap: NDRV must be at least 2");
   end

   if (SWAP_EN) begin : g_swap
      always_comb begin
         ds_o  = ds_i;
         mtr_o = mtr_i;
         if (swap_i) begin
            ds_o[0]  = ds_i[1];
            ds_o[1]  = ds_i[0];
            mtr_o[0] = mtr_i[1];
            mtr_o[1] = mtr_i[0];
         end
      end
   end else begin : g_pass
      assign ds_o  = ds_i;
      assign mtr_o = mtr_i;
   end
endmodule

// File: rtl/cfg_bank_top.sv
module cfg_bank_top
   import cfg_bank_pkg::*;
#(
   parameter int unsigned DW        = 8,
   parameter int unsigned IW        = 8,
   parameter int unsigned NDRV      = 2,
   parameter int unsigned PMUX_W    = 5,
   parameter logic [PMUX_W-1:0] BLOCK_VAL = 5'b10011,
   parameter bit          BLOCK_EN  = 1'b1,
   parameter bit          SWAP_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_rate_i,
   input  logic              pwrdn_pin_i,
   input  logic              bus_wr_i,
   input  logic              bus_port_i,
   input  logic [DW-1:0]     bus_wdata_i,
   output logic [DW-1:0]     bus_rdata_o,
   input  logic [NDRV-1:0]   fdc_ds_i,
   input  logic [NDRV-1:0]   fdc_mtr_i,
   output logic [NDRV-1:0]   pin_ds_o,
   output logic [NDRV-1:0]   pin_mtr_o,
   input  logic [PMUX_W-1:0] pmux_in_i,
   output logic [PMUX_W-1:0] pmux_in_o,
   output logic              pmux_en_o,
   output logic              pmux_drive_o,
   output logic              clk_stop_o,
   output logic              osc_stop_o,
   output logic [1:0]        uart_test_o,
   output logic              lpt_irq7_o,
   output logic              lpt_level_o,
   output logic              rate_out_o
);
   logic [REG_CNT-1:0][DW-1:0] cfg_regs;
   logic [IW-1:0]              idx_q;
   logic                       lock_q;
   logic [DW-1:0]              sel_r, pwr_r, pin_r;
   logic [1:0]                 lpt_base;
   logic                       xchg_eff;
   logic                       pwr_req;

   cfg_reg_store #(.DW(DW), .IW(IW), .NREG(REG_CNT)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .strap_i (strap_rate_i),
      .wr_i    (bus_wr_i),
      .port_i  (bus_port_i),
      .wdata_i (bus_wdata_i),
      .rdata_o (bus_rdata_o),
      .regs_o  (cfg_regs),
      .idx_o   (idx_q),
      .lock_o  (lock_q)
   );

   assign sel_r    = cfg_regs[IDX_SEL];
   assign pwr_r    = cfg_regs[IDX_PWR];
   assign pin_r    = cfg_regs[IDX_PIN];
   assign lpt_base = sel_r[1:0];

   assign pwr_req     = pwrdn_pin_i | pwr_r[PWR_SWDN];
   assign clk_stop_o  = pwr_req & ~pwr_r[PWR_OSC];
   assign osc_stop_o  = pwr_req &  pwr_r[PWR_OSC];
   assign uart_test_o = {pwr_r[PWR_TST1], pwr_r[PWR_TST0]};

   cfg_lpt_route #(.ROUTE_CODE(BASE_378)) u_route (
      .base_i    (lpt_base),
      .irq_sel_i (pwr_r[PWR_IRQ7]),
      .mode_i    (pwr_r[PWR_LEVEL]),
      .irq7_o    (lpt_irq7_o),
      .level_o   (lpt_level_o)
   );

   assign pmux_en_o    = pin_r[PIN_MUXEN];
   assign pmux_drive_o = ~pin_r[PIN_FLOAT];
   assign rate_out_o   = pin_r[PIN_RATE];

   if (BLOCK_EN) begin : g_block
      assign pmux_in_o = pin_r[PIN_FLOAT] ? BLOCK_VAL : pmux_in_i;
   end else begin : g_noblock
      assign pmux_in_o = pmux_in_i;
   end

   assign xchg_eff = pin_r[PIN_XCHG] & ~sel_r[SEL_FOURDRV];

   cfg_drive_swap #(.NDRV(NDRV), .SWAP_EN(SWAP_EN)) u_swap (
      .swap_i (xchg_eff),
      .ds_i   (fdc_ds_i),
      .mtr_i  (fdc_mtr_i),
      .ds_o   (pin_ds_o),
      .mtr_o  (pin_mtr_o)
   );
endmodule

// File: rtl/cfg_bank_chk.sv
module cfg_bank_chk #(
   parameter int unsigned DW     = 8,
   parameter int unsigned IW     = 8,
   parameter int unsigned NDRV   = 2,
   parameter int unsigned PMUX_W = 5,
   parameter int unsigned NREG   = 3,
   parameter logic [PMUX_W-1:0] BLOCK_VAL = 5'b10011
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lock_q,
   input logic [IW-1:0]     idx_q,
   input logic [1:0]        lpt_base,
   input logic              xchg_eff,
   input logic              bus_wr_i,
   input logic              bus_port_i,
   input logic [DW-1:0]     bus_rdata_o,
   input logic [NDRV-1:0]   fdc_ds_i,
   input logic [NDRV-1:0]   pin_ds_o,
   input logic [PMUX_W-1:0] pmux_in_o,
   input logic              pmux_drive_o,
   input logic [1:0]        uart_test_o,
   input logic              lpt_irq7_o,
   input logic              lpt_level_o,
   input logic              pmux_en_o,
   input logic              rate_out_o,
   input logic              clk_stop_o,
   input logic              osc_stop_o
);
   // R4
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q);

   // R4
   locked_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && bus_wr_i && bus_port_i) |=>
      $stable({uart_test_o, lpt_irq7_o, lpt_level_o, pmux_en_o, pmux_drive_o, rate_out_o}));

   // R2
   unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_port_i && idx_q >= IW'(NREG)) |-> bus_rdata_o == '0);

   // R7
   irq7_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lpt_irq7_o |-> lpt_base == 2'b01);

   // R10
   float_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pmux_drive_o |-> pmux_in_o == BLOCK_VAL);

   // R11
   no_swap_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !xchg_eff |-> pin_ds_o == fdc_ds_i);

   // R11
   swap_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(pin_ds_o) == $countones(fdc_ds_i));

   // R6
   pwr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(clk_stop_o && osc_stop_o));
endmodule

bind cfg_bank_top cfg_bank_chk #(
   .DW(DW), .IW(IW), .NDRV(NDRV), .PMUX_W(PMUX_W), .NREG(3), .BLOCK_VAL(BLOCK_VAL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .lock_q(lock_q), .idx_q(idx_q), .lpt_base(lpt_base),
   .xchg_eff(xchg_eff), .bus_wr_i(bus_wr_i), .bus_port_i(bus_port_i),
   .bus_rdata_o(bus_rdata_o), .fdc_ds_i(fdc_ds_i), .pin_ds_o(pin_ds_o),
   .pmux_in_o(pmux_in_o), .pmux_drive_o(pmux_drive_o), .uart_test_o(uart_test_o),
   .lpt_irq7_o(lpt_irq7_o), .lpt_level_o(lpt_level_o), .pmux_en_o(pmux_en_o),
   .rate_out_o(rate_out_o), .clk_stop_o(clk_stop_o), .osc_stop_o(osc_stop_o)
);

// File: tb/cfg_bank_top_bench.sv
`timescale 1ns/1ps
module cfg_bank_top_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       strap_rate_i = 1'b1;
   logic       pwrdn_pin_i = 1'b0;
   logic       bus_wr_i = 1'b0;
   logic       bus_port_i = 1'b0;
   logic [7:0] bus_wdata_i = '0;
   logic [7:0] bus_rdata_o;
   logic [1:0] fdc_ds_i = 2'b01;
   logic [1:0] fdc_mtr_i = 2'b10;
   logic [1:0] pin_ds_o, pin_mtr_o;
   logic [4:0] pmux_in_i = 5'b01100;
   logic [4:0] pmux_in_o;
   logic       pmux_en_o, pmux_drive_o, clk_stop_o, osc_stop_o;
   logic [1:0] uart_test_o;
   logic       lpt_irq7_o, lpt_level_o, rate_out_o;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #2 clk = ~clk;

   cfg_bank_top u_cfg_bank_top (.*);

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic strap);
      @(negedge clk);
      strap_rate_i = strap;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      strap_rate_i = ~strap;
   endtask

   task automatic wr(input logic port, input logic [7:0] d);
      @(negedge clk);
      bus_port_i = port; bus_wdata_i = d; bus_wr_i = 1'b1;
      @(negedge clk);
      bus_wr_i = 1'b0;
   endtask

   task automatic wreg(input logic [7:0] idx, input logic [7:0] d);
      wr(1'b0, idx);
      wr(1'b1, d);
   endtask

   task automatic rd(input logic [7:0] idx, output logic [7:0] v);
      wr(1'b0, idx);
      bus_port_i = 1'b1;
      #1 v = bus_rdata_o;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      do_reset(1'b1);
      rd(8'd0, v); chk("R3 sel reset", v, 8'h00);
      rd(8'd1, v); chk("R3 pwr reset", v, 8'h00);
      rd(8'd2, v); chk("R3 pin reset strap", v, 8'h01);
      chk("R12 rate from strap", rate_out_o, 1'b1);
      chk("R6 no power-down at reset", {clk_stop_o, osc_stop_o}, 2'b00);
      chk("R11 no swap at reset", {pin_ds_o, pin_mtr_o}, {fdc_ds_i, fdc_mtr_i});
   endtask

   task automatic t_access();
      logic [7:0] v;
      wreg(8'd0, 8'hA4);
      rd(8'd0, v); chk("R1 data readback", v, 8'hA4);
      bus_port_i = 1'b0;
      #1 chk("R1 index readback", bus_rdata_o, 8'h00);
      wreg(8'd0, 8'h00);
   endtask

   task automatic t_unimpl();
      logic [7:0] v;
      wreg(8'd5, 8'hFF);
      rd(8'd5, v); chk("R2 unimplemented reads zero", v, 8'h00);
      rd(8'd0, v); chk("R2 sel untouched", v, 8'h00);
      rd(8'd2, v); chk("R2 pin untouched", v, 8'h01);
   endtask

   task automatic t_fields();
      logic [7:0] v;
      wreg(8'd1, 8'hBF);
      wreg(8'd2, 8'hFF);
      rd(8'd1, v); chk("R5 pwr reserved reads 0", v, 8'hBB);
      rd(8'd2, v); chk("R5 pin reserved reads 0", v, 8'hFD);
      chk("R8 level mode", lpt_level_o, 1'b1);
      chk("R9 test modes", uart_test_o, 2'b11);
      chk("R10 mux enable", pmux_en_o, 1'b1);
      chk("R10 mux float", pmux_drive_o, 1'b0);
      chk("R10 blocked inputs", pmux_in_o, 5'b10011);
      wreg(8'd2, 8'h04);
      chk("R10 inputs pass", pmux_in_o, 5'b01100);
      chk("R10 mux driven", pmux_drive_o, 1'b1);
      chk("R12 rate cleared", rate_out_o, 1'b0);
      wreg(8'd1, 8'h00);
      chk("R8 pulse mode", lpt_level_o, 1'b0);
      chk("R9 test off", uart_test_o, 2'b00);
   endtask

   task automatic t_power();
      wreg(8'd1, 8'h01);
      chk("R6 sw clock stop", {clk_stop_o, osc_stop_o}, 2'b10);
      wreg(8'd1, 8'h03);
      chk("R6 sw osc stop", {clk_stop_o, osc_stop_o}, 2'b01);
      wreg(8'd1, 8'h00);
      chk("R6 idle", {clk_stop_o, osc_stop_o}, 2'b00);
      pwrdn_pin_i = 1'b1;
      #1 chk("R6 pin clock stop", {clk_stop_o, osc_stop_o}, 2'b10);
      pwrdn_pin_i = 1'b0;
   endtask

   task automatic t_irq();
      wreg(8'd1, 8'h08);
      for (int c = 0; c < 4; c++) begin
         wreg(8'd0, 8'(c));
         chk($sformatf("R7 base code %0d", c), lpt_irq7_o, (c == 1) ? 1'b1 : 1'b0);
      end
      wreg(8'd0, 8'h01);
      wreg(8'd1, 8'h00);
      chk("R7 select off", lpt_irq7_o, 1'b0);
      wreg(8'd0, 8'h00);
   endtask

   task automatic t_swap();
      wreg(8'd2, 8'h10);
      chk("R11 swapped ds", pin_ds_o, 2'b10);
      chk("R11 swapped mtr", pin_mtr_o, 2'b01);
      fdc_ds_i = 2'b10; fdc_mtr_i = 2'b11;
      #1 chk("R11 swap follows inputs", {pin_ds_o, pin_mtr_o}, 4'b0111);
      wreg(8'd0, 8'h10);
      chk("R11 four-drive unswapped", {pin_ds_o, pin_mtr_o}, 4'b1011);
      wreg(8'd0, 8'h00);
      wreg(8'd2, 8'h00);
      chk("R11 exchange off", {pin_ds_o, pin_mtr_o}, 4'b1011);
      fdc_ds_i = 2'b01; fdc_mtr_i = 2'b10;
   endtask

   task automatic t_lock();
      logic [7:0] v;
      wreg(8'd1, 8'h48);
      rd(8'd1, v); chk("R4 locking write stored", v, 8'h48);
      wreg(8'd2, 8'hFF);
      rd(8'd2, v); chk("R4 pin frozen", v, 8'h00);
      wreg(8'd1, 8'h00);
      rd(8'd1, v); chk("R4 lock stays", v, 8'h48);
      bus_port_i = 1'b0;
      #1 chk("R4 index writable", bus_rdata_o, 8'h01);
      do_reset(1'b0);
      rd(8'd1, v); chk("R4 reset clears lock", v, 8'h00);
      rd(8'd2, v); chk("R3 strap low", v, 8'h00);
      wreg(8'd2, 8'h04);
      rd(8'd2, v); chk("R4 writable after reset", v, 8'h04);
   endtask

   initial begin
      t_reset();
      t_access();
      t_unimpl();
      t_fields();
      t_power();
      t_irq();
      t_swap();
      t_lock();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule